// File: doc/BRIEF.md
# Timer Burst Register Refresh Sequencer

On every timer update event this block opens a burst, pulls a fixed number of words from a valid/ready stream, and turns each accepted word into a register write strobe. A single data window is used. The target register index advances by one per word, starting at a configured word offset. This lets one linear DMA stream refresh a run of neighbouring compare registers together in each update period. The stream is laid out row by row: one row per update event, and one word per selected channel in ascending order.

The configuration has two fields. `cfg_base` is the word offset of the first target register, which is the byte offset from the first control register divided by four. `cfg_len` is the number of extra transfers, so a value of 0 gives a single write per update. Both fields are captured when a burst opens. `req` asks the stream source for data only while a burst is open.

Back-pressure rules: `s_ready` is high exactly while a burst is open. A word moves when `s_valid` and `s_ready` are both high on a rising clock edge. The write strobe, address and data appear in that same cycle. The source may hold `s_valid` low for any number of cycles, which stalls the burst. Words offered while no burst is open are neither taken nor written.

Top module: `tdbs_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after release, `req`, `s_ready`, `reg_we` and `overrun` are all 0.
- R2: An `upd_evt` pulse sampled while no burst is open opens a burst, and `req` and `s_ready` are 1 from the next cycle.
- R3: `reg_wdata` equals `s_data` and `reg_we` is 1 in exactly the cycles where `s_valid` and `s_ready` are both 1.
- R4: A burst performs exactly `cfg_len`+1 writes. The k-th write (k from 0) goes to `reg_addr` = `cfg_base` + k, with `reg_addr` one bit wider than the wider of the two fields so the sum never wraps.
- R5: In the cycle after the final word of a burst is accepted, `req` and `s_ready` are 0, unless R10 applies.
- R6: An `upd_evt` sampled during an open burst, and not on its final accepted word, drives `overrun` to 1 for exactly the next cycle. The burst continues from where it stood, with its remaining addresses unchanged.
- R7: Changing `cfg_base` or `cfg_len` while a burst is open has no effect on that burst's addresses or word count.
- R8: While a burst is open and `s_valid` is 0, `reg_we` is 0 and the burst position does not advance.
- R9: While no burst is open, `s_ready` is 0 and `reg_we` stays 0 whatever `s_valid` does. A later burst still starts at its base.
- R10: An `upd_evt` sampled in the same cycle as the final word's acceptance opens a new burst at once, using the configuration present in that cycle, and does not raise `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_evt | input | 1 | One-cycle timer update event |
| cfg_base | input | BASE_W | Word offset of the first target register |
| cfg_len | input | LEN_W | Transfers per burst minus one |
| s_valid | input | 1 | Stream word available |
| s_ready | output | 1 | Sequencer accepts a word this cycle |
| s_data | input | DATA_W | Stream word |
| req | output | 1 | Data request to the stream source |
| reg_we | output | 1 | Register write strobe |
| reg_addr | output | BASE_W/LEN_W max + 1 | Word index of the register written |
| reg_wdata | output | DATA_W | Data written |
| overrun | output | 1 | One-cycle pulse: update arrived mid-burst |

## Verification
The final word of a burst being accepted and a fresh update event can fall in the same cycle. This decides whether the event is an overrun or the start of the next back-to-back burst. The bench provokes it by raising `upd_evt` together with `s_valid` on the last word, with a new base and length on the configuration pins. It then judges that `overrun` stays low, that `req` stays high, and that the next writes walk the new base for the new length. A separate case raises `upd_evt` on a middle word while `s_valid` is low, and expects the overrun pulse with no restart of the address walk.

// File: rtl/tdbs_pkg.sv
package tdbs_pkg;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_BURST = 1'b1
  } seq_state_e;

  function automatic int unsigned wider(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tdbs_ctrl.sv
module tdbs_ctrl
  import tdbs_pkg::*;
#(
  parameter int unsigned LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_evt,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             s_valid,
  output logic             busy,
  output logic             accept,
  output logic             start,
  output logic [LEN_W-1:0] idx,
  output logic             overrun
);

  seq_state_e       state_q;
  logic [LEN_W-1:0] len_q;
  logic             last_acc;

  assign busy     = (state_q == SEQ_BURST);
  assign accept   = busy && s_valid;
  assign last_acc = accept && (idx == len_q);
  assign start    = upd_evt && (!busy || last_acc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx     <= '0;
      len_q   <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= upd_evt && busy && !last_acc;
      if (start) begin
        state_q <= SEQ_BURST;
        idx     <= '0;
        len_q   <= cfg_len;
      end else if (last_acc) begin
        state_q <= SEQ_IDLE;
        idx     <= '0;
      end else if (accept) begin
        idx <= idx + 1'b1;
      end
    end
  end

  AST_OPEN_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && !busy) |=> (busy && idx == '0)); // R2
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !last_acc && !upd_evt) |=> (idx == $past(idx) + 1'b1)); // R4
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx <= len_q)); // R4
  AST_CLOSE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (last_acc && !upd_evt) |=> !busy); // R5
  AST_OVERRUN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && busy && !last_acc) |=> (overrun && busy)); // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && busy && !accept) |=> (idx == $past(idx))); // R6
  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !upd_evt) |=> $stable(len_q)); // R7
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !s_valid && !upd_evt) |=> (busy && idx == $past(idx))); // R8
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (last_acc && upd_evt) |=> (busy && !overrun && idx == '0)); // R10

endmodule

// File: rtl/tdbs_addr.sv
module tdbs_addr #(
  parameter int unsigned BASE_W = 5,
  parameter int unsigned LEN_W  = 5,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic [LEN_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);

  logic [BASE_W-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (start) begin
      base_q <= cfg_base;
    end
  end

  assign addr = ADDR_W'(base_q) + ADDR_W'(idx);

  AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(base_q)); // R7

endmodule

// File: rtl/tdbs_seq.sv
module tdbs_seq
  import tdbs_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BASE_W = 5,
  parameter int unsigned LEN_W  = 5,
  localparam int unsigned ADDR_W = wider(BASE_W, LEN_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_evt,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              req,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              overrun
);

  logic             busy;
  logic             accept;
  logic             start;
  logic [LEN_W-1:0] idx;

  tdbs_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_evt (upd_evt),
    .cfg_len (cfg_len),
    .s_valid (s_valid),
    .busy    (busy),
    .accept  (accept),
    .start   (start),
    .idx     (idx),
    .overrun (overrun)
  );

  tdbs_addr #(.BASE_W(BASE_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cfg_base (cfg_base),
    .idx      (idx),
    .addr     (reg_addr)
  );

  assign req       = busy;
  assign s_ready   = busy;
  assign reg_we    = accept;
  assign reg_wdata = s_data;

  AST_WRITE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (req && s_valid)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && !upd_evt) |=> (!reg_we && !overrun)); // R9

endmodule

// File: tb/tdbs_seq_bench.sv
module tdbs_seq_bench;

  localparam int D_W = 16;
  localparam int B_W = 5;
  localparam int L_W = 5;
  localparam int A_W = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           upd_evt = 1'b0;
  logic [B_W-1:0] cfg_base = '0;
  logic [L_W-1:0] cfg_len = '0;
  logic           s_valid = 1'b0;
  logic           s_ready;
  logic [D_W-1:0] s_data = '0;
  logic           req;
  logic           reg_we;
  logic [A_W-1:0] reg_addr;
  logic [D_W-1:0] reg_wdata;
  logic           overrun;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tdbs_seq #(.DATA_W(D_W), .BASE_W(B_W), .LEN_W(L_W)) u_tdbs_seq (
    .clk(clk), .rst_n(rst_n), .upd_evt(upd_evt), .cfg_base(cfg_base),
    .cfg_len(cfg_len), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .req(req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .overrun(overrun)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [D_W-1:0] pat(input int b, input int i);
    return D_W'(16'h5a00 + b * 37 + i * 11);
  endfunction

  task automatic open_burst(input int b, input int l);
    @(negedge clk);
    cfg_base = B_W'(b); cfg_len = L_W'(l); upd_evt = 1'b1;
    @(negedge clk);
    upd_evt = 1'b0;
    cfg_base = ~B_W'(b); cfg_len = ~L_W'(l); // R7 scramble
    #1;
    check(req && s_ready, "R2 req after event", int'(req), 1);
  endtask

  // one word at position i; on return the accepting edge has passed
  task automatic push_word(input int b, input int i, input bit stall);
    if (stall) begin
      s_valid = 1'b0;
      #1;
      check(!reg_we, "R8 no write while stalled", int'(reg_we), 0);
      @(negedge clk);
    end
    s_valid = 1'b1; s_data = pat(b, i);
    #1;
    check(reg_we, "R3 strobe on handshake", int'(reg_we), 1);
    check(reg_addr == A_W'(b + i), "R4 address", int'(reg_addr), b + i);
    check(reg_wdata == pat(b, i), "R3 data", int'(reg_wdata), int'(pat(b, i)));
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic close_check();
    #1;
    check(!req && !s_ready, "R5 request drops", int'(req), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1;
    check(!req && !s_ready && !reg_we && !overrun, "R1 reset state", int'(req), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!req && !reg_we && !overrun, "R1 after release", int'(overrun), 0);

    // R9: words offered while idle are ignored
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = 16'hdead;
      #1;
      check(!s_ready && !reg_we, "R9 idle ignores stream", int'(reg_we), 0);
    end
    @(negedge clk); s_valid = 1'b0;

    // R4 sweep: bases x every length, with and without stalls
    for (int bi = 0; bi < 4; bi++) begin
      int b;
      b = (bi == 0) ? 0 : (bi == 1) ? 7 : (bi == 2) ? 18 : 31;
      for (int l = 0; l < 32; l++) begin
        bit gaps;
        gaps = ((l + bi) % 2) == 1;
        open_burst(b, l);
        for (int i = 0; i <= l; i++) push_word(b, i, gaps && (i % 2 == 1));
        close_check();
        #1;
        check(!reg_we, "R4 no extra write", int'(reg_we), 0);
      end
    end

    // R6: update mid-burst flags overrun and does not restart
    open_burst(9, 3);
    push_word(9, 0, 1'b0);
    upd_evt = 1'b1; cfg_base = 5'd2; cfg_len = 5'd0;
    @(negedge clk);
    upd_evt = 1'b0;
    #1;
    check(overrun, "R6 overrun pulse", int'(overrun), 1);
    check(req, "R6 burst still open", int'(req), 1);
    @(negedge clk);
    #1;
    check(!overrun, "R6 pulse is one cycle", int'(overrun), 0);
    for (int i = 1; i <= 3; i++) push_word(9, i, 1'b0);
    close_check();

    // R10: event on the final accepted word starts a new burst at once
    open_burst(4, 1);
    push_word(4, 0, 1'b0);
    s_valid = 1'b1; s_data = pat(4, 1);
    upd_evt = 1'b1; cfg_base = 5'd20; cfg_len = 5'd2;
    #1;
    check(reg_we && reg_addr == A_W'(5), "R10 final word written", int'(reg_addr), 5);
    @(negedge clk);
    upd_evt = 1'b0; s_valid = 1'b0; cfg_base = 5'd1; cfg_len = 5'd9;
    #1;
    check(!overrun, "R10 no overrun", int'(overrun), 0);
    check(req, "R10 new burst open", int'(req), 1);
    for (int i = 0; i <= 2; i++) push_word(20, i, i == 1);
    close_check();

    // R9 again: idle after bursts, then a fresh burst starts at its base
    @(negedge clk); s_valid = 1'b1;
    #1;
    check(!reg_we, "R9 idle after burst", int'(reg_we), 0);
    @(negedge clk); s_valid = 1'b0;
    open_burst(12, 0);
    push_word(12, 0, 1'b0);
    close_check();

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule